// File: doc/BRIEF.md
# Half-Word Immediate Logic and Shift Unit

This datapath block performs bitwise AND, OR and XOR on a 32-bit register operand, taking the second operand either from a second register or from a 16-bit immediate. The immediate is placed in the upper or the lower half of the word, and the remaining half is filled with all zeros or all ones as the instruction requests. Filling with ones lets an AND keep the untouched half unchanged. An XOR with 0xFFFF in the low half and a ones fill gives a bitwise NOT.

The same block shifts the register operand by a 5-bit immediate count. One direction bit picks left or right, and one mode bit picks a logical or a sign-filling right shift. A carry-enable bit routes the last bit shifted out into the carry flag.

Each accepted operation registers its result. It also updates the zero and negative flags unless the flag-disable bit is set. Instruction decode and the register file sit outside the block.

Top module: `hwi_logic_shift`

## Requirements
- R1: After reset, `result_o` is 0 and `flag_z_o`, `flag_n_o`, `flag_c_o` are 0.
- R2: With `valid_i`=1 and `use_imm_i`=0, `func_i` 00/01/10 writes A AND B, A OR B and A XOR B to `result_o` at the next clock edge.
- R3: With `use_imm_i`=1, the immediate occupies result bits 15:0 of the second operand when `hi_sel_i`=0 and bits 31:16 when `hi_sel_i`=1.
- R4: With `use_imm_i`=1, every bit of the other half of the second operand equals `fill_i`. So AND with `fill_i`=1 preserves that half, and XOR with 0xFFFF low and `fill_i`=1 inverts the low half.
- R5: `func_i`=11 shifts A by `shamt_i` (0..31): left when `dir_right_i`=0, right when 1, with zeros shifted in. `use_imm_i` and B are ignored.
- R6: A right shift with `arith_i`=1 fills vacated bits with A[31]. `arith_i` has no effect on a left shift.
- R7: An accepted operation with `no_flags_i`=0 sets `flag_z_o` to (result==0) and `flag_n_o` to result bit 31.
- R8: With `no_flags_i`=1, all three flags keep their values while the result is still written.
- R9: A shift with `carry_en_i`=1, `no_flags_i`=0 and `shamt_i`≠0 loads `flag_c_o` with the last bit shifted out (A[32-n] left, A[n-1] right). Logic ops, a zero count or `carry_en_i`=0 leave the carry unchanged.
- R10: With `valid_i`=0, the result and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation accepted this cycle |
| func_i | input | 2 | 00 AND, 01 OR, 10 XOR, 11 shift |
| use_imm_i | input | 1 | Logic second operand from the immediate |
| opnd_a_i | input | 32 | Register operand A |
| opnd_b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Half-word immediate |
| hi_sel_i | input | 1 | Place the immediate in the upper half |
| fill_i | input | 1 | Fill value for the unused half |
| shamt_i | input | 5 | Shift count |
| dir_right_i | input | 1 | 1 shifts right, 0 shifts left |
| arith_i | input | 1 | Sign-filling right shift |
| carry_en_i | input | 1 | Shift loads carry |
| no_flags_i | input | 1 | Suppress all flag updates |
| result_o | output | 32 | Registered result |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The bench targets shift counts of 0, 1 and 31 in both directions. A wrong carry tap would load a neighbouring bit, and a missing zero-count guard would clear the carry. Arithmetic right shifts of negative values are checked, and so is the arithmetic bit on left shifts, where a leaky mode mux would smear the sign. Upper-half placement with both fill values is exercised, where a swapped half or a fill on the wrong side corrupts the preserved bits. Flag-disable and idle cycles are also covered, which would expose flags or results that update regardless of the control bits.

// File: rtl/hwi_pkg.sv
package hwi_pkg;
  typedef enum logic [1:0] {
    FN_AND   = 2'b00,
    FN_OR    = 2'b01,
    FN_XOR   = 2'b10,
    FN_SHIFT = 2'b11
  } fn_e;
endpackage

// File: rtl/hwi_imm_place.sv
module hwi_imm_place #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             hi_sel_i,
  input  logic             fill_i,
  output logic [W-1:0]     word_o
);
  localparam int PAD_W = W - IMM_W;

  always_comb begin
    if (hi_sel_i) word_o = {imm_i, {PAD_W{fill_i}}};
    else          word_o = {{PAD_W{fill_i}}, imm_i};
  end

  // R4
  always_comb begin
    if (!hi_sel_i)
      fill_lo_chk: assert ($countones(word_o[W-1:IMM_W]) == (fill_i ? PAD_W : 0));
  end
endmodule

// File: rtl/hwi_shifter.sv
module hwi_shifter #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic           right_i,
  input  logic           arith_i,
  output logic [W-1:0]   res_o,
  output logic           cout_o
);
  logic         sfill;
  logic [W:0]   lx;
  logic [2*W:0] rx;

  assign sfill = arith_i & a_i[W-1];

  always_comb begin
    lx = {1'b0, a_i} << shamt_i;
    rx = {{W{sfill}}, a_i, 1'b0} >> shamt_i;
    if (right_i) begin
      res_o  = rx[W:1];
      cout_o = rx[0];
    end else begin
      res_o  = lx[W-1:0];
      cout_o = lx[W];
    end
  end
endmodule

// File: rtl/hwi_logic_shift.sv
module hwi_logic_shift
  import hwi_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  localparam int SHW  = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       func_i,
  input  logic             use_imm_i,
  input  logic [W-1:0]     opnd_a_i,
  input  logic [W-1:0]     opnd_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             hi_sel_i,
  input  logic             fill_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic             dir_right_i,
  input  logic             arith_i,
  input  logic             carry_en_i,
  input  logic             no_flags_i,
  output logic [W-1:0]     result_o,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_c_o
);
  fn_e          fn;
  logic [W-1:0] imm_word, opnd_b, logic_res, shift_res, res;
  logic         shift_cout, is_shift, upd_flags, upd_carry;

  assign fn = fn_e'(func_i);

  hwi_imm_place #(.W(W), .IMM_W(IMM_W)) u_place (
    .imm_i(imm_i), .hi_sel_i(hi_sel_i), .fill_i(fill_i), .word_o(imm_word)
  );

  hwi_shifter #(.W(W)) u_shift (
    .a_i(opnd_a_i), .shamt_i(shamt_i), .right_i(dir_right_i),
    .arith_i(arith_i), .res_o(shift_res), .cout_o(shift_cout)
  );

  assign opnd_b = use_imm_i ? imm_word : opnd_b_i;

  always_comb begin
    unique case (fn)
      FN_AND:  logic_res = opnd_a_i & opnd_b;
      FN_OR:   logic_res = opnd_a_i | opnd_b;
      FN_XOR:  logic_res = opnd_a_i ^ opnd_b;
      default: logic_res = '0;
    endcase
  end

  assign is_shift  = (fn == FN_SHIFT);
  assign res       = is_shift ? shift_res : logic_res;
  assign upd_flags = valid_i & ~no_flags_i;
  assign upd_carry = upd_flags & is_shift & carry_en_i & (shamt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flag_z_o <= 1'b0;
      flag_n_o <= 1'b0;
      flag_c_o <= 1'b0;
    end else begin
      if (valid_i) result_o <= res;
      if (upd_flags) begin
        flag_z_o <= (res == '0);
        flag_n_o <= res[W-1];
      end
      if (upd_carry) flag_c_o <= shift_cout;
    end
  end

  // R8
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && no_flags_i) |=> $stable({flag_z_o, flag_n_o, flag_c_o}));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable({flag_z_o, flag_n_o, flag_c_o})));

  // R9
  carry_logic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_shift) |=> $stable(flag_c_o));

  // R9
  carry_zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && shamt_i == '0) |=> $stable(flag_c_o));

  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !no_flags_i) |=> (flag_z_o == (result_o == '0)) && (flag_n_o == result_o[W-1]));

  // R5
  shift_zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_shift && shamt_i == '0) |=> (result_o == $past(opnd_a_i)));
endmodule

// File: tb/hwi_logic_shift_test.sv
module hwi_logic_shift_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  func_i = '0;
  logic        use_imm_i = 1'b0;
  logic [31:0] opnd_a_i = '0, opnd_b_i = '0;
  logic [15:0] imm_i = '0;
  logic        hi_sel_i = 1'b0, fill_i = 1'b0;
  logic [4:0]  shamt_i = '0;
  logic        dir_right_i = 1'b0, arith_i = 1'b0, carry_en_i = 1'b0, no_flags_i = 1'b0;
  logic [31:0] result_o;
  logic        flag_z_o, flag_n_o, flag_c_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_res = '0;
  logic m_z = 0, m_n = 0, m_c = 0;

  always #5 clk = ~clk;

  hwi_logic_shift uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .func_i(func_i),
    .use_imm_i(use_imm_i), .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i),
    .imm_i(imm_i), .hi_sel_i(hi_sel_i), .fill_i(fill_i), .shamt_i(shamt_i),
    .dir_right_i(dir_right_i), .arith_i(arith_i), .carry_en_i(carry_en_i),
    .no_flags_i(no_flags_i), .result_o(result_o), .flag_z_o(flag_z_o),
    .flag_n_o(flag_n_o), .flag_c_o(flag_c_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [1:0] fn, input logic ui,
                      input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                      input logic hi, input logic fl, input int sh, input logic dr,
                      input logic ar, input logic ce, input logic nf);
    logic [31:0] bop, r, x;
    logic cy;
    string ftag;
    valid_i = v; func_i = fn; use_imm_i = ui; opnd_a_i = a; opnd_b_i = b; imm_i = imm;
    hi_sel_i = hi; fill_i = fl; shamt_i = 5'(sh); dir_right_i = dr; arith_i = ar;
    carry_en_i = ce; no_flags_i = nf;
    // reference model
    if (ui) begin
      bop = fl ? 32'hFFFF_FFFF : 32'h0;
      for (int i = 0; i < 16; i++) begin
        if (hi) bop[16+i] = imm[i];
        else    bop[i] = imm[i];
      end
    end else bop = b;
    cy = m_c;
    case (fn)
      2'd0: r = a & bop;
      2'd1: r = a | bop;
      2'd2: r = a ^ bop;
      default: begin
        x = a;
        for (int i = 0; i < sh; i++) begin
          if (dr) begin cy = x[0]; x = {ar & x[31], x[31:1]}; end
          else    begin cy = x[31]; x = {x[30:0], 1'b0}; end
        end
        r = x;
      end
    endcase
    if (v) begin
      m_res = r;
      if (!nf) begin
        m_z = (r == 0);
        m_n = r[31];
        if (fn == 2'd3 && ce && sh != 0) m_c = cy;
      end
    end
    ftag = !v ? "R10" : (nf ? "R8" : "R7");
    @(posedge clk);
    @(negedge clk);
    chk(tag, result_o, m_res);
    chk(ftag, {31'b0, flag_z_o}, {31'b0, m_z});
    chk(ftag, {31'b0, flag_n_o}, {31'b0, m_n});
    chk((!v || nf) ? ftag : "R9", {31'b0, flag_c_o}, {31'b0, m_c});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", result_o, 32'h0);
    chk("R1", {29'b0, flag_z_o, flag_n_o, flag_c_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R2 register-register logic
    step("R2", 1, 2'd0, 0, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 2'd1, 0, 32'h8000_0001, 32'h0000_0100, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 2'd2, 0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 placement high / low
    step("R3", 1, 2'd1, 1, 32'h0, 0, 16'hA5C3, 1, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 2'd1, 1, 32'h0, 0, 16'hA5C3, 0, 0, 0, 0, 0, 0, 0);
    // R4 fill: AND preserves other half with ones fill, NOT via XOR
    step("R4", 1, 2'd0, 1, 32'h1234_5678, 0, 16'h00FF, 0, 1, 0, 0, 0, 0, 0);
    step("R4", 1, 2'd0, 1, 32'h1234_5678, 0, 16'h0F0F, 1, 1, 0, 0, 0, 0, 0);
    step("R4", 1, 2'd0, 1, 32'h1234_5678, 0, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 2'd2, 1, 32'h1234_5678, 0, 16'hFFFF, 0, 1, 0, 0, 0, 0, 0);
    step("R4", 1, 2'd1, 1, 32'h0000_0000, 0, 16'h0001, 1, 1, 0, 0, 0, 0, 0);
    // R5 / R9 shifts with carry
    step("R5", 1, 2'd3, 0, 32'h8000_0001, 0, 0, 0, 0, 1, 0, 0, 1, 0);
    step("R5", 1, 2'd3, 0, 32'h0000_0003, 0, 0, 0, 0, 1, 1, 0, 1, 0);
    step("R9", 1, 2'd3, 0, 32'h0000_0002, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    step("R9", 1, 2'd3, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 31, 0, 0, 1, 0);
    step("R9", 1, 2'd3, 0, 32'h0000_0001, 0, 0, 0, 0, 31, 1, 0, 0, 0);
    step("R9", 1, 2'd0, 0, 32'h0, 32'h0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R6 arithmetic right and left ignoring arith
    step("R6", 1, 2'd3, 0, 32'h8000_0000, 0, 0, 0, 0, 31, 1, 1, 1, 0);
    step("R6", 1, 2'd3, 0, 32'h9000_0010, 0, 0, 0, 0, 4, 1, 1, 1, 0);
    step("R6", 1, 2'd3, 0, 32'hC000_0001, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    step("R6", 1, 2'd3, 0, 32'h7000_0000, 0, 0, 0, 0, 8, 1, 1, 0, 0);
    // R8 flag disable
    step("R8", 1, 2'd2, 0, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 1, 2'd3, 0, 32'h0000_0001, 0, 0, 0, 0, 1, 1, 0, 1, 1);
    // R10 idle
    step("R10", 0, 2'd1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R10", 0, 2'd3, 0, 32'h1, 0, 0, 0, 0, 3, 1, 0, 1, 0);
    // mixed sequences
    for (int k = 0; k < 400; k++) begin
      logic [1:0] fn;
      fn = 2'($urandom_range(0, 3));
      step(fn == 2'd3 ? "R5" : "R2", ($urandom_range(0, 7) != 0), fn, 1'($urandom),
           $urandom, $urandom, 16'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(0, 31), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 4) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule